// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sequences the serial clock of an I2C master and tells a byte engine when to act on the data line. It counts every phase in input-clock cycles. A register bank outside the block supplies four counts: the whole SCL period, the low part of it, the hold and setup interval that frames START and STOP conditions, and the lead that SDA needs before SCL rises. The total period is the input clock rate divided by the bus rate, so a 100 MHz input gives 1000 for 100 kHz and 250 for 400 kHz. Software normally programs the low count to 5/9 of the period, the condition count to half of it and the data lead to 1/16 of it. The high phase is whatever the period leaves after the low phase.

The byte engine issues one command at a time while `ready` is high: a START, a single bit clock, or a STOP. The block drives `sclLow` to pull the open-drain SCL line down and releases it otherwise. It pulses `sdaChange` when SDA may be updated, `sdaSample` when SDA should be captured, `startEdge` when SDA must fall with SCL high, and `stopEdge` when SDA must rise with SCL high. After releasing SCL, the block waits for the line to read back high (`sclIn`, already synchronised to `clk`) before it counts any high or setup time. A slave that stretches the clock therefore adds its delay to the phase instead of shortening it. A START issued while the block holds the bus becomes a repeated START.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, and on the clock edge following any cycle with `forceReset` high, `sclLow` is 0, `ready` is 1 and no strobe is active. `forceReset` abandons any transfer in progress.
- R2: START from the released idle state: let Cc = max(cfgCond,1). If sample 0 is the first cycle after the accepting edge, `startEdge` pulses once, in sample Cc-1. `sclLow` first reads 1 in sample 2Cc, and `ready` is 1 in that sample.
- R3: A command accepted while the bus is held (cmdOp 0 = bit, 1 = START, 2 = STOP) keeps `sclLow` at 1 for exactly Lc samples from sample 0, where Lc = max(cfgLow,1).
- R4: During that low phase, `sdaChange` pulses exactly once, De samples before the first sample with `sclLow` = 0. De = min(max(cfgDataSetup,1), Lc).
- R5: Bit command: let h0 be the first sample with SCL released and `sclIn` high. `sclLow` returns to 1 in sample h0+Hc+1, where Pc = max(cfgPeriod,1) and Hc = Pc-Lc if Pc > Lc, else 1. `ready` is 1 in that sample.
- R6: While `sclIn` stays low after release, no high-phase counting takes place. With the line held low for S extra samples, h0 is the release sample plus S+1, and R5 still holds relative to h0.
- R7: Each bit command gives exactly one `sdaSample` pulse, in sample h0+1.
- R8: STOP command (op 2): `stopEdge` pulses in sample h0+Cc. SCL stays released, and `ready` first returns in sample h0+Cc+Lc+1 (the bus-free time equals Lc).
- R9: START command while the bus is held (repeated START): `startEdge` pulses in sample h0+Cc, and `sclLow` returns to 1 in sample h0+2Cc+1.
- R10: Bit and STOP commands in the idle state, and op 3 in any state, are ignored: `sclLow` and `ready` keep their values and no strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all phases are counted in |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgPeriod | input | CNT_W | Clocks per SCL period |
| cfgLow | input | CNT_W | Clocks SCL is held low |
| cfgCond | input | CNT_W | START hold, repeated-START setup and STOP setup clocks |
| cfgDataSetup | input | CNT_W | Clocks from SDA update to SCL release |
| cmdValid | input | 1 | Command present; taken when `ready` is high |
| cmdOp | input | 2 | 0 bit, 1 START, 2 STOP, 3 no operation |
| forceReset | input | 1 | Synchronous abort to idle with counter cleared |
| sclIn | input | 1 | Synchronised SCL line readback |
| sclLow | output | 1 | 1 pulls SCL low |
| ready | output | 1 | Idle or holding the bus; a command may be issued |
| sdaChange | output | 1 | SDA may be updated this cycle |
| sdaSample | output | 1 | Capture SDA this cycle |
| startEdge | output | 1 | Pull SDA low now (START) |
| stopEdge | output | 1 | Release SDA now (STOP) |

## Verification
The bench builds the block with CNT_W = 4, so every setting of interest fits in a few cycles. This makes a near-exhaustive sweep affordable: eight periods, six low counts, two condition counts and four data-lead values, which is 384 settings. Each setting runs START, plain bits, a bit with clock stretching, a repeated START and a STOP. The small widths reach every clamp: zero settings, a data lead longer than the low phase, and a low count at or above the period. The SCL line is modelled as a registered open-drain wire that the bench can hold low.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

  typedef enum logic [1:0] {
    OP_BIT   = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_NONE  = 2'd3
  } opCode_e;

  typedef enum logic [1:0] {
    LD_LOW  = 2'd0,
    LD_HIGH = 2'd1,
    LD_COND = 2'd2
  } loadSel_e;

  // strobes from sequencing control to the counting datapath
  typedef struct packed {
    logic     clear;
    logic     load;
    loadSel_e sel;
  } cntCtl_t;

endpackage

// File: rtl/i2c_tgen_dp.sv
module i2c_tgen_dp
  import i2c_tgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgCond,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  cntCtl_t          ctl,
  output logic             cntZero,
  output logic             atDataPoint,
  output logic             atHighStart
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] periodEff, lowEff, condEff, dsuRaw, dsuEff, highEff;
  logic [CNT_W-1:0] loadVal, cnt;

  // zero settings become one clock; derived high and data-lead counts
  always_comb begin
    periodEff = (cfgPeriod == '0) ? ONE : cfgPeriod;
    lowEff    = (cfgLow == '0) ? ONE : cfgLow;
    condEff   = (cfgCond == '0) ? ONE : cfgCond;
    dsuRaw    = (cfgDataSetup == '0) ? ONE : cfgDataSetup;
    dsuEff    = (dsuRaw > lowEff) ? lowEff : dsuRaw;
    highEff   = (periodEff > lowEff) ? (periodEff - lowEff) : ONE;
    unique case (ctl.sel)
      LD_LOW:  loadVal = lowEff;
      LD_HIGH: loadVal = highEff;
      default: loadVal = condEff;
    endcase
  end

  // counter holds remaining cycles minus one; a phase of N lasts N cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (ctl.clear)      cnt <= '0;
    else if (ctl.load)       cnt <= loadVal - ONE;
    else if (cnt != '0)      cnt <= cnt - ONE;
  end

  assign cntZero     = (cnt == '0);
  assign atDataPoint = (cnt == dsuEff - ONE);
  assign atHighStart = (cnt == highEff - ONE);

endmodule

// File: rtl/i2c_tgen_ctl.sv
module i2c_tgen_ctl
  import i2c_tgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmdValid,
  input  opCode_e cmdOp,
  input  logic    forceReset,
  input  logic    sclIn,
  input  logic    cntZero,
  input  logic    atDataPoint,
  input  logic    atHighStart,
  output cntCtl_t ctl,
  output logic    sclLow,
  output logic    ready,
  output logic    sdaChange,
  output logic    sdaSample,
  output logic    startEdge,
  output logic    stopEdge
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_HELD, ST_LOW, ST_WAITHI, ST_HIGH,
    ST_SSETUP, ST_SHOLD, ST_PSETUP, ST_BUSFREE
  } phase_e;

  phase_e  state, stateNext;
  opCode_e pendOp, pendNext;
  logic    sclLowNext;

  always_comb begin
    stateNext  = state;
    pendNext   = pendOp;
    sclLowNext = sclLow;
    ctl        = '{clear: 1'b0, load: 1'b0, sel: LD_LOW};
    if (forceReset) begin
      stateNext  = ST_IDLE;
      pendNext   = OP_NONE;
      sclLowNext = 1'b0;
      ctl.clear  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (cmdValid && cmdOp == OP_START) begin
          stateNext = ST_SSETUP;
          ctl.load  = 1'b1;
          ctl.sel   = LD_COND;
        end
        ST_HELD: if (cmdValid && cmdOp != OP_NONE) begin
          stateNext = ST_LOW;
          pendNext  = cmdOp;
          ctl.load  = 1'b1;
          ctl.sel   = LD_LOW;
        end
        ST_LOW: if (cntZero) begin
          sclLowNext = 1'b0;
          stateNext  = ST_WAITHI;
        end
        ST_WAITHI: if (sclIn) begin
          ctl.load = 1'b1;
          unique case (pendOp)
            OP_BIT:   begin stateNext = ST_HIGH;   ctl.sel = LD_HIGH; end
            OP_START: begin stateNext = ST_SSETUP; ctl.sel = LD_COND; end
            default:  begin stateNext = ST_PSETUP; ctl.sel = LD_COND; end
          endcase
        end
        ST_HIGH, ST_SHOLD: if (cntZero) begin
          sclLowNext = 1'b1;
          stateNext  = ST_HELD;
        end
        ST_SSETUP: if (cntZero) begin
          stateNext = ST_SHOLD;
          ctl.load  = 1'b1;
          ctl.sel   = LD_COND;
        end
        ST_PSETUP: if (cntZero) begin
          stateNext = ST_BUSFREE;
          ctl.load  = 1'b1;
          ctl.sel   = LD_LOW;
        end
        ST_BUSFREE: if (cntZero) stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pendOp <= OP_NONE;
      sclLow <= 1'b0;
    end else begin
      state  <= stateNext;
      pendOp <= pendNext;
      sclLow <= sclLowNext;
    end
  end

  assign ready     = (state == ST_IDLE) || (state == ST_HELD);
  assign sdaChange = (state == ST_LOW) && atDataPoint;
  assign sdaSample = (state == ST_HIGH) && atHighStart;
  assign startEdge = (state == ST_SSETUP) && cntZero;
  assign stopEdge  = (state == ST_PSETUP) && cntZero;

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgCond,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             forceReset,
  input  logic             sclIn,
  output logic             sclLow,
  output logic             ready,
  output logic             sdaChange,
  output logic             sdaSample,
  output logic             startEdge,
  output logic             stopEdge
);
  cntCtl_t ctl;
  logic    cntZero, atDataPoint, atHighStart;

  i2c_tgen_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(opCode_e'(cmdOp)),
    .forceReset(forceReset), .sclIn(sclIn), .cntZero(cntZero),
    .atDataPoint(atDataPoint), .atHighStart(atHighStart), .ctl(ctl),
    .sclLow(sclLow), .ready(ready), .sdaChange(sdaChange),
    .sdaSample(sdaSample), .startEdge(startEdge), .stopEdge(stopEdge)
  );

  i2c_tgen_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgPeriod(cfgPeriod), .cfgLow(cfgLow),
    .cfgCond(cfgCond), .cfgDataSetup(cfgDataSetup), .ctl(ctl),
    .cntZero(cntZero), .atDataPoint(atDataPoint), .atHighStart(atHighStart)
  );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic forceReset,
  input logic sclLow,
  input logic ready,
  input logic sdaChange,
  input logic sdaSample,
  input logic startEdge,
  input logic stopEdge
);
  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forceReset |=> (!sclLow && ready));
  // R4
  data_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdaChange |-> sclLow);
  // R7
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdaSample |-> !sclLow);
  // R2
  start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startEdge |-> !sclLow);
  // R8
  stop_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopEdge |-> !sclLow);
  // R5
  low_entry_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclLow) |-> ready);
  // R3
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclLow) && !$past(forceReset)) |-> !ready);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdaChange, sdaSample, startEdge, stopEdge}));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .forceReset(forceReset), .sclLow(sclLow),
  .ready(ready), .sdaChange(sdaChange), .sdaSample(sdaSample),
  .startEdge(startEdge), .stopEdge(stopEdge)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] cfgPeriod = '0, cfgLow = '0, cfgCond = '0, cfgDataSetup = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd3;
  logic forceReset = 1'b0;
  logic stretch = 1'b0;
  logic sclBus = 1'b1;
  logic sclLow, ready, sdaChange, sdaSample, startEdge, stopEdge;

  int checks = 0, fails = 0;
  bit done = 0;
  int Lc, Hc, Cc, De;

  i2c_scl_timer #(.CNT_W(W)) u_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n), .cfgPeriod(cfgPeriod), .cfgLow(cfgLow),
    .cfgCond(cfgCond), .cfgDataSetup(cfgDataSetup), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .forceReset(forceReset), .sclIn(sclBus), .sclLow(sclLow),
    .ready(ready), .sdaChange(sdaChange), .sdaSample(sdaSample),
    .startEdge(startEdge), .stopEdge(stopEdge)
  );

  // open-drain SCL wire seen through one register, optionally held low
  always @(posedge clk) sclBus <= !sclLow && !stretch;

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (P=%0d L=%0d C=%0d D=%0d)",
               req, what, act, exp, cfgPeriod, cfgLow, cfgCond, cfgDataSetup);
    end
  endtask

  function automatic int cl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic setCfg(input int p, input int l, input int c, input int d);
    @(negedge clk);
    cfgPeriod = W'(p); cfgLow = W'(l); cfgCond = W'(c); cfgDataSetup = W'(d);
    Lc = cl1(l);
    Hc = (cl1(p) > Lc) ? cl1(p) - Lc : 1;
    Cc = cl1(c);
    De = (cl1(d) > Lc) ? Lc : cl1(d);
  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd3;
  endtask

  function automatic int strobes();
    return int'(sdaChange) + int'(sdaSample) + int'(startEdge) + int'(stopEdge);
  endfunction

  task automatic runStart();
    int edgAt = -1, edgCnt = 0, lowAt = -1, rdy = 0;
    issue(2'd1);
    for (int k = 0; k < 100; k++) begin
      if (startEdge) begin if (edgAt < 0) edgAt = k; edgCnt++; end
      if (sclLow) begin lowAt = k; rdy = int'(ready); break; end
      @(negedge clk);
    end
    expectEq("R2", "startEdge sample", edgAt, Cc - 1);
    expectEq("R2", "startEdge count", edgCnt, 1);
    expectEq("R2", "scl low sample", lowAt, 2 * Cc);
    expectEq("R2", "ready after start", rdy, 1);
  endtask

  task automatic runHeld(input logic [1:0] op, input int stretchN);
    int relAt = -1, chgAt = -1, chgCnt = 0, h0 = -1, smpAt = -1, smpCnt = 0;
    int edgAt = -1, edgCnt = 0, endAt = -1, endLow = 0, endRdy = 0;
    string hiTag;
    hiTag = (stretchN > 0) ? "R6" : "R5";
    stretch = (stretchN > 0);
    issue(op);
    for (int k = 0; k < 400; k++) begin
      if (sdaChange) begin if (chgAt < 0) chgAt = k; chgCnt++; end
      if (sdaSample) begin if (smpAt < 0) smpAt = k; smpCnt++; end
      if (startEdge || stopEdge) begin if (edgAt < 0) edgAt = k; edgCnt++; end
      if (relAt < 0 && !sclLow) relAt = k;
      if (relAt >= 0 && h0 < 0 && sclBus && !sclLow) h0 = k;
      if (relAt >= 0 && ((op == 2'd2) ? ready : sclLow)) begin
        endAt = k; endLow = int'(sclLow); endRdy = int'(ready); break;
      end
      if (relAt >= 0 && k >= relAt + stretchN) stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
    expectEq("R3", "low phase length", relAt, Lc);
    expectEq("R4", "sdaChange sample", chgAt, Lc - De);
    expectEq("R4", "sdaChange count", chgCnt, 1);
    expectEq(hiTag, "first high readback", h0, relAt + stretchN + 1);
    case (op)
      2'd0: begin
        expectEq("R7", "sdaSample sample", smpAt, h0 + 1);
        expectEq("R7", "sdaSample count", smpCnt, 1);
        expectEq(hiTag, "scl low again", endAt, h0 + Hc + 1);
        expectEq(hiTag, "ready after bit", endRdy, 1);
        expectEq("R5", "no condition edge in bit", edgCnt, 0);
      end
      2'd1: begin
        expectEq("R9", "repeated startEdge sample", edgAt, h0 + Cc);
        expectEq("R9", "scl low after repeated start", endAt, h0 + 2 * Cc + 1);
      end
      default: begin
        expectEq("R8", "stopEdge sample", edgAt, h0 + Cc);
        expectEq("R8", "ready after bus free", endAt, h0 + Cc + Lc + 1);
        expectEq("R8", "scl released after stop", endLow, 0);
      end
    endcase
  endtask

  task automatic watchIgnored(input logic [1:0] op, input int expLow, input string what);
    issue(op);
    for (int k = 0; k < 4; k++) begin
      expectEq("R10", {what, " sclLow"}, int'(sclLow), expLow);
      expectEq("R10", {what, " ready"}, int'(ready), 1);
      expectEq("R10", {what, " strobes"}, strobes(), 0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expectEq("R1", "reset sclLow", int'(sclLow), 0);
    expectEq("R1", "reset ready", int'(ready), 1);
    expectEq("R1", "reset strobes", strobes(), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 8; p++)
      for (int l = 0; l < 6; l++)
        for (int ci = 0; ci < 2; ci++)
          for (int di = 0; di < 4; di++) begin
            setCfg(p, l, ci * 2, (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 6);
            runStart();
            runHeld(2'd0, 0);
            runHeld(2'd0, 2);
            runHeld(2'd1, 0);
            runHeld(2'd0, 0);
            runHeld(2'd2, 0);
          end

    // R10: ignored commands while idle, then op 3 while holding
    setCfg(6, 4, 2, 1);
    watchIgnored(2'd0, 0, "bit in idle");
    watchIgnored(2'd2, 0, "stop in idle");
    watchIgnored(2'd3, 0, "noop in idle");
    runStart();
    watchIgnored(2'd3, 1, "noop while held");

    // R1: forced reset in the middle of a low phase
    issue(2'd0);
    forceReset = 1'b1;
    @(negedge clk);
    forceReset = 1'b0;
    expectEq("R1", "forced reset sclLow", int'(sclLow), 0);
    expectEq("R1", "forced reset ready", int'(ready), 1);
    expectEq("R1", "forced reset strobes", strobes(), 0);
    repeat (2) @(negedge clk);
    runStart();
    runHeld(2'd0, 0);
    runHeld(2'd2, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule